// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Controller

This block sits on each card of a shared backplane and decides when the card is the bus master. Mastership moves around a daisy chain as a level difference. A card is master while the level it drives on its grant output differs from the level it senses on its grant input. A card that does not want the bus copies its input level to its output, which passes the token to the next slot. A card that wants the bus holds its output at the old level, drives the active-low ownership line low and tells its local master engine that it has been granted.

Two other backplane lines are used. The first is a cycle-in-progress input, which is high while any slot holds the bus. A card that has just received the token waits for this line to go quiet before it takes the bus. The second is a shared, active-low, open-drain clear line, through which waiting cards ask the current owner to give the bus up. A priority requester pulls the clear line as soon as it starts waiting. An ordinary requester pulls it only after it has waited longer than a programmable limit. When an owner sees the clear line asserted, it asks its engine to stop, lets the engine finish the transfer in progress, and then releases the bus. All backplane inputs pass through a two-stage synchronizer. Every output is registered.

Top module: `chain_grant_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no stimulus: `grant_out`=0, `own_n`=1, `granted`=0, `clear_pull`=0, `yield_req`=0.
- R2: With `req` low, a change of `grant_in` appears on `grant_out` three clock edges later (two synchronizer stages plus the output register).
- R3: When a `grant_in` change arrives with `req` high and `cyc_busy` low, `own_n` goes low and `granted` goes high three edges after the change. `grant_out` keeps its old level, so it differs from `grant_in`.
- R4: `own_n` is low exactly when `granted` is high. While the card owns the bus, `grant_out` is the complement of the synchronized `grant_in`.
- R5: If `cyc_busy` is high when the token arrives, the card keeps the token (`grant_out` unchanged) without owning the bus. It takes ownership three edges after `cyc_busy` falls.
- R6: An owner whose `req` is low releases on the next edge: `own_n`=1, `granted`=0, and `grant_out` equals `grant_in`.
- R7: An owner that sees `clear_n_in` low while `xfer_busy` is high keeps the bus and raises `yield_req`. It releases on the first edge at which `xfer_busy` is low.
- R8: For the first three clock edges of a tenure, `clear_n_in` is ignored, so the card's own clear request cannot echo back through the synchronizer.
- R9: A waiting card (`req` high, no token) with `prio` high raises `clear_pull` one edge after it starts waiting.
- R10: A waiting card with `prio` low raises `clear_pull` `pass_limit`+1 edges after it starts waiting (one edge when `pass_limit`=0). It never pulls while it owns the bus, and it drops the pull on the edge at which it takes the bus.
- R11: If `grant_in` changes again while the card owns the bus, the card stays the owner and `grant_out` follows the complement of `grant_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pass_limit | input | CNT_W | Wait limit, in clocks, before an ordinary requester pulls the clear line |
| req | input | 1 | Local engine wants the bus |
| prio | input | 1 | Local request is priority traffic |
| xfer_busy | input | 1 | Local engine is in the middle of a transfer |
| granted | output | 1 | Card currently owns the bus |
| yield_req | output | 1 | Asks the engine to finish its transfer and let go |
| grant_in | input | 1 | Grant level from the upstream slot |
| grant_out | output | 1 | Grant level to the downstream slot |
| own_n | output | 1 | Ownership line, active low |
| clear_n_in | input | 1 | Sensed level of the shared clear line, active low |
| clear_pull | output | 1 | Enable for the open-drain pull-down on the clear line |
| cyc_busy | input | 1 | Backplane cycle-in-progress indication |

## Verification
Three events can land on the same clock edge: the clear line becomes visible to an owner, that owner's transfer ends, and the tenure guard runs out. The bench keeps `xfer_busy` high while the clear line is held low across the guard window. It then checks that `yield_req` rises on the exact edge the guard expires and that the release follows one edge after `xfer_busy` drops. A second collision is between a waiting card's own clear pull and the token arriving. There the bench checks that ownership and the withdrawal of the pull happen on the same edge.

// File: rtl/chain_grant_pkg.sv
// Shared definitions for the daisy-chain grant controller.
package chain_grant_pkg;

    // Ownership state of one card.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // passing the token through
        ST_PEND = 2'd1,  // token held, waiting for the bus to go quiet
        ST_OWN  = 2'd2   // card is bus master
    } cg_state_e;

    // Bit positions inside the synchronized input vector.
    localparam int SYN_GRANT = 0;
    localparam int SYN_CLEAR = 1;
    localparam int SYN_BUSY  = 2;
    localparam int SYN_W     = 3;

endpackage

// File: rtl/cg_sync.sv
// Multi-bit, multi-stage level synchronizer.
// Assumes every bit is an independent level, so a bit may lag or lead
// its neighbours by one clock. Each bit resets to its own value.
module cg_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the sampled levels along the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cg_wait_timer.sv
// Counts the clocks a card spends waiting for the token. It reports
// expiry once the count reaches the programmed limit. The count
// saturates and clears whenever the card stops waiting.
module cg_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] wait_q;

    // Advance while waiting, hold at the top, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!waiting) begin
            wait_q <= '0;
        end else if (wait_q != CNT_MAX) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assign expired = (wait_q >= limit);

endmodule

// File: rtl/cg_tenure_guard.sv
// Blanks the clear line at the start of each tenure. A card that pulled
// the clear line itself still sees it low through the synchronizer for a
// few clocks after it wins. This guard keeps that echo from ending the
// new tenure at once.
module cg_tenure_guard #(
    parameter int GUARD   = 3,
    parameter int GUARD_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tenure,
    output logic done
);

    localparam logic [GUARD_W-1:0] GUARD_END = GUARD_W'(GUARD);

    logic [GUARD_W-1:0] age_q;

    // Age the tenure up to the guard length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (!tenure) begin
            age_q <= '0;
        end else if (age_q != GUARD_END) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign done = (age_q == GUARD_END);

endmodule

// File: rtl/cg_master_fsm.sv
// Ownership state machine for one slot of the chain.
// Assumes all backplane inputs arrive already synchronized. Every
// output is registered, so the grant output moves only on a clock edge.
module cg_master_fsm
    import chain_grant_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gi_s,
    input  logic clr_n_s,
    input  logic busy_s,
    input  logic req,
    input  logic prio,
    input  logic xfer_busy,
    input  logic expired,
    input  logic guard_done,
    output logic waiting,
    output logic tenure,
    output logic grant_out,
    output logic own_n,
    output logic granted,
    output logic clear_pull,
    output logic yield_req
);

    cg_state_e st_q, st_nx;
    logic      gout_nx;
    logic      arrive;
    logic      clr_act;
    logic      release_now;

    // A token has arrived when the input level no longer matches the
    // level being passed on while the card is idle.
    assign arrive      = (gi_s != grant_out);
    assign clr_act     = guard_done && !clr_n_s;
    assign release_now = !req || (clr_act && !xfer_busy);
    assign waiting     = (st_q == ST_IDLE) && req && !arrive;
    assign tenure      = (st_q == ST_OWN);

    // Next state and next grant level.
    always_comb begin
        st_nx   = st_q;
        gout_nx = grant_out;
        case (st_q)
            ST_IDLE: begin
                if (arrive) begin
                    if (!req) begin
                        gout_nx = gi_s;
                    end else if (busy_s) begin
                        st_nx = ST_PEND;
                    end else begin
                        st_nx = ST_OWN;
                    end
                end
            end
            ST_PEND: begin
                if (!req) begin
                    st_nx   = ST_IDLE;
                    gout_nx = gi_s;
                end else begin
                    gout_nx = ~gi_s;
                    if (!busy_s) begin
                        st_nx = ST_OWN;
                    end
                end
            end
            ST_OWN: begin
                if (release_now) begin
                    st_nx   = ST_IDLE;
                    gout_nx = gi_s;
                end else begin
                    gout_nx = ~gi_s;
                end
            end
            default: begin
                st_nx   = ST_IDLE;
                gout_nx = gi_s;
            end
        endcase
    end

    // Register state and every backplane-facing output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            grant_out  <= 1'b0;
            own_n      <= 1'b1;
            granted    <= 1'b0;
            clear_pull <= 1'b0;
            yield_req  <= 1'b0;
        end else begin
            st_q       <= st_nx;
            grant_out  <= gout_nx;
            own_n      <= (st_nx != ST_OWN);
            granted    <= (st_nx == ST_OWN);
            clear_pull <= (st_nx == ST_IDLE) && req && (prio || expired);
            yield_req  <= (st_q == ST_OWN) && !release_now && clr_act;
        end
    end

endmodule

// File: rtl/chain_grant_ctrl.sv
// Per-card bus grant controller for a daisy-chained backplane.
// Synchronizes the grant, clear and cycle-busy lines, then drives the
// grant output, the ownership line and the clear-line pull enable.
// Assumes the open-drain drivers and the backplane busy OR sit outside.
module chain_grant_ctrl
    import chain_grant_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pass_limit,
    input  logic             req,
    input  logic             prio,
    input  logic             xfer_busy,
    output logic             granted,
    output logic             yield_req,
    input  logic             grant_in,
    output logic             grant_out,
    output logic             own_n,
    input  logic             clear_n_in,
    output logic             clear_pull,
    input  logic             cyc_busy
);

    localparam int GUARD   = SYNC_STAGES + 1;
    localparam int GUARD_W = $clog2(GUARD + 1);
    localparam logic [SYN_W-1:0] SYN_RST = SYN_W'(1) << SYN_CLEAR;

    logic [SYN_W-1:0] raw_in, syn_out;
    logic gi_s, clr_n_s, busy_s;
    logic waiting, expired, tenure, guard_done;

    // Collect the asynchronous backplane inputs into one vector.
    always_comb begin
        raw_in            = '0;
        raw_in[SYN_GRANT] = grant_in;
        raw_in[SYN_CLEAR] = clear_n_in;
        raw_in[SYN_BUSY]  = cyc_busy;
    end

    cg_sync #(
        .WIDTH   (SYN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_out)
    );

    assign gi_s    = syn_out[SYN_GRANT];
    assign clr_n_s = syn_out[SYN_CLEAR];
    assign busy_s  = syn_out[SYN_BUSY];

    cg_wait_timer #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .limit   (pass_limit),
        .expired (expired)
    );

    cg_tenure_guard #(
        .GUARD   (GUARD),
        .GUARD_W (GUARD_W)
    ) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .tenure (tenure),
        .done   (guard_done)
    );

    cg_master_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gi_s       (gi_s),
        .clr_n_s    (clr_n_s),
        .busy_s     (busy_s),
        .req        (req),
        .prio       (prio),
        .xfer_busy  (xfer_busy),
        .expired    (expired),
        .guard_done (guard_done),
        .waiting    (waiting),
        .tenure     (tenure),
        .grant_out  (grant_out),
        .own_n      (own_n),
        .granted    (granted),
        .clear_pull (clear_pull),
        .yield_req  (yield_req)
    );

endmodule

// File: rtl/chain_grant_checker.sv
// Temporal checks on the grant controller, attached by bind.
module chain_grant_checker (
    input logic clk,
    input logic rst_n,
    input logic gi_s,
    input logic req,
    input logic grant_out,
    input logic own_n,
    input logic granted,
    input logic clear_pull,
    input logic yield_req
);

    AST_OWN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        own_n == !granted); // R4

    AST_OWN_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        !own_n |-> (grant_out != $past(gi_s))); // R4

    AST_REQ_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_n && !req) |=> own_n); // R6

    AST_YIELD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        yield_req |-> !own_n); // R7

    AST_GUARD_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_n) |=> !yield_req); // R8

    AST_NO_PULL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !own_n |-> !clear_pull); // R10

endmodule

bind chain_grant_ctrl chain_grant_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gi_s       (gi_s),
    .req        (req),
    .grant_out  (grant_out),
    .own_n      (own_n),
    .granted    (granted),
    .clear_pull (clear_pull),
    .yield_req  (yield_req)
);

// File: tb/sim_chain_grant_ctrl.sv
module sim_chain_grant_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pass_limit = 8'd10;
    logic       req = 1'b0, prio = 1'b0, xfer_busy = 1'b0;
    logic       grant_in = 1'b0, clear_n_in = 1'b1, cyc_busy = 1'b0;
    logic       granted, yield_req, grant_out, own_n, clear_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chain_grant_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_limit (pass_limit),
        .req        (req),
        .prio       (prio),
        .xfer_busy  (xfer_busy),
        .granted    (granted),
        .yield_req  (yield_req),
        .grant_in   (grant_in),
        .grant_out  (grant_out),
        .own_n      (own_n),
        .clear_n_in (clear_n_in),
        .clear_pull (clear_pull),
        .cyc_busy   (cyc_busy)
    );

    // Inputs {grant_in, req, prio, clear_n_in, cyc_busy, xfer_busy},
    // expected {grant_out, own_n, granted, clear_pull, yield_req}
    // after one edge. pass_limit = 10, starting from a fresh reset.
    localparam logic [10:0] VEC [13] = '{
        {6'b100100, 5'b01000},  // R2 change seen by sync stage 1
        {6'b100100, 5'b01000},  // R2 stage 2
        {6'b100100, 5'b11000},  // R2 mirrored on third edge
        {6'b110100, 5'b11000},  // R10 waiting, below limit
        {6'b010100, 5'b11000},  // R3 token arrives
        {6'b010100, 5'b11000},  // R3
        {6'b010100, 5'b10100},  // R3 owner, grant_out kept
        {6'b010001, 5'b10100},  // R8 clear low, guard running
        {6'b010001, 5'b10100},  // R8
        {6'b010001, 5'b10100},  // R8 guard last edge
        {6'b010001, 5'b10101},  // R7 yield raised with transfer busy
        {6'b010000, 5'b01000},  // R7 release when transfer ends
        {6'b000100, 5'b01000}   // R2 idle again
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; req = 1'b0; prio = 1'b0; xfer_busy = 1'b0;
        grant_in = 1'b0; clear_n_in = 1'b1; cyc_busy = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(1);
        do_reset();
        check("R1 reset outputs", {3'b0, grant_out, own_n, granted, clear_pull, yield_req}, 8'b0000_1000);

        // Vector table walk.
        for (int i = 0; i < 13; i++) begin
            {grant_in, req, prio, clear_n_in, cyc_busy, xfer_busy} = VEC[i][10:5];
            step(1);
            check($sformatf("R2/R3/R7/R8/R10 vector %0d", i),
                  {3'b0, grant_out, own_n, granted, clear_pull, yield_req}, {3'b0, VEC[i][4:0]});
        end

        // Priority pull, then token arrival drops it.
        do_reset();
        req = 1'b1; prio = 1'b1;
        step(1);
        check("R9 priority pull", {7'b0, clear_pull}, 8'd1);
        grant_in = 1'b1;
        step(3);
        check("R3 granted on arrival", {6'b0, granted, own_n}, 8'b10);
        check("R10 pull dropped on win", {7'b0, clear_pull}, 8'd0);
        check("R3 grant_out differs", {7'b0, grant_out}, 8'd0);
        grant_in = 1'b0;
        step(3);
        check("R11 still owner", {7'b0, granted}, 8'd1);
        check("R11 grant_out complement", {7'b0, grant_out}, 8'd1);
        req = 1'b0;
        step(1);
        check("R6 release on req drop", {6'b0, own_n, grant_out}, 8'b10);

        // Ordinary requester with limit 4.
        pass_limit = 8'd4;
        do_reset();
        req = 1'b1;
        step(4);
        check("R10 no pull before limit", {7'b0, clear_pull}, 8'd0);
        step(1);
        check("R10 pull at limit+1", {7'b0, clear_pull}, 8'd1);
        pass_limit = 8'd0;
        do_reset();
        req = 1'b1;
        step(1);
        check("R10 zero limit pulls at once", {7'b0, clear_pull}, 8'd1);

        // Busy backplane defers ownership.
        pass_limit = 8'd200;
        do_reset();
        cyc_busy = 1'b1; req = 1'b1; grant_in = 1'b1;
        step(6);
        check("R5 deferred while busy", {6'b0, granted, grant_out}, 8'b00);
        cyc_busy = 1'b0;
        step(2);
        check("R5 not yet owner", {7'b0, granted}, 8'd0);
        step(1);
        check("R5 owner after busy falls", {6'b0, granted, own_n}, 8'b10);

        // Reset during a tenure.
        rst_n = 1'b0;
        step(1);
        check("R1 reset mid tenure", {4'b0, grant_out, own_n, granted, yield_req}, 8'b0100);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule